// File: doc/BRIEF.md
# Start-up Reset Sequencer

This block decides when a core may leave reset after power is applied or after an external reset request. A power-on event starts a sequence of up to two waits: a power-up wait measured in ticks of a separate slow timebase, then a crystal settling wait measured in oscillator cycles. Either wait can drop out. A configuration input turns off the power-up wait. The settling wait applies only when the oscillator mode selects a crystal. The core is held in reset until the sequence ends and the external reset pin is released.

The external pin is active low and asynchronous, and passes through a synchronizer. A pin reset never starts either wait again. When the pin is held low until both waits have ended, execution resumes right after release, two oscillator cycles later. In the first cycle that the hold drops, a single-cycle restart pulse marks the event. The four-phase instruction clock generator starts at phase 0 in that cycle, so release timing is exact to one oscillator cycle.

The sequencer has four states. ST_BOOT is entered on power-on. ST_PUP_WAIT is the power-up wait. ST_XTAL_WAIT is the crystal settling wait. ST_RUN is the final state. The transitions are:
- BOOT to PUP_WAIT when the power-up wait is enabled.
- BOOT to XTAL_WAIT when that wait is disabled and the mode is a crystal mode.
- BOOT to RUN otherwise.
- PUP_WAIT to XTAL_WAIT or RUN on the final tick, depending on the mode.
- XTAL_WAIT to RUN on the final cycle.
- RUN stays in RUN until the next power-on.

Top module: `startup_reset_seq`

## Requirements
- R1: While `por` is high, and asynchronously on its assertion, `hold_rst` is 1, `restart_pulse` is 0 and `phase` is 0. `hold_rst` stays 1 in every state other than ST_RUN.
- R2: With `pup_en`=1, the first edge after `por` falls enters the power-up wait. That wait counts only `slow_tick` pulses. The edge that samples the PUP_TICKS-th tick ends it, and the wait has no limit in clock cycles.
- R3: In a crystal mode (`osc_mode` 00, 01 or 10), the settling wait lasts exactly XTAL_CYCLES clock edges after the edge that enters it. `hold_rst` falls after the last of those edges.
- R4: With `osc_mode`=11 (non-crystal), the settling wait is skipped. Release follows directly after the power-up wait, or after ST_BOOT when that wait is disabled.
- R5: With `pup_en`=0, the power-up wait is skipped and the edge after `por` falls goes to the settling wait or to ST_RUN.
- R6: `rst_pin_n` passes through a two-flop synchronizer that resets to "asserted". `hold_rst` rises in the second cycle after the pin falls and falls in the second cycle after it rises. A pin reset from ST_RUN never re-runs either wait, and ticks seen during it have no effect.
- R7: If the pin is held low until both waits have ended, `hold_rst` stays 1 for as long as the pin is low. After release it falls two cycles later.
- R8: `restart_pulse` is high for exactly one cycle, the first cycle in which `hold_rst` is 0 after being 1.
- R9: `phase` is 0 while `hold_rst` is 1 and in the restart cycle. It then steps 1, 2, 3, 0 on each clock.
- R10: `slow_tick` pulses outside the power-up wait, including during the settling wait, do not change the release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por | input | 1 | Power-on event, active high, asynchronous assertion |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| slow_tick | input | 1 | One-cycle tick from the slow timebase, in the clk domain |
| pup_en | input | 1 | Enables the power-up wait |
| osc_mode | input | 2 | 00/01/10 crystal modes, 11 non-crystal |
| hold_rst | output | 1 | Keeps the core in reset |
| restart_pulse | output | 1 | One-cycle pulse on reset release |
| phase | output | $clog2(PHASES) | Instruction clock phase |

## Verification
The hardest case to reach is a pin reset that outlasts both waits. The pin has to be low before power-on and stay low through every power-up tick and every settling cycle. Only then does its release show the short two-cycle path. The bench holds the pin low across a full shortened sequence and then waits many more cycles before releasing it. It then forces a second pin reset from ST_RUN, with more ticks than the power-up wait needs, to show that neither wait comes back.

// File: rtl/startup_reset_seq_pkg.sv
package startup_reset_seq_pkg;

    typedef enum logic [1:0] {
        ST_BOOT      = 2'd0,
        ST_PUP_WAIT  = 2'd1,
        ST_XTAL_WAIT = 2'd2,
        ST_RUN       = 2'd3
    } seq_state_e;

    localparam logic [1:0] OSC_NONXTAL = 2'b11;

    function automatic logic needs_settle(input logic [1:0] mode);
        return mode != OSC_NONXTAL;
    endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic pin_n,
    output logic pin_n_sync
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or posedge por) begin
        if (por) shreg <= '0;
        else     shreg <= {shreg[STAGES-2:0], pin_n};
    end

    assign pin_n_sync = shreg[STAGES-1];
endmodule

// File: rtl/span_counter.sv
module span_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic por,
    input  logic run,
    input  logic step,
    output logic done
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign done = run && step && (cnt == LAST);

    always_ff @(posedge clk or posedge por) begin
        if (por)        cnt <= '0;
        else if (!run)  cnt <= '0;
        else if (done)  cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/phase_gen.sv
module phase_gen #(
    parameter int PHASES = 4
) (
    input  logic                        clk,
    input  logic                        por,
    input  logic                        hold,
    output logic [$clog2(PHASES)-1:0]   phase
);
    localparam int PW = $clog2(PHASES);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    always_ff @(posedge clk or posedge por) begin
        if (por)                phase <= '0;
        else if (hold)          phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    // R9: a held cycle leaves the generator at phase 0 for the next cycle
    a_r9_frozen_in_hold: assert property (@(posedge clk) disable iff (por)
        hold |=> (phase == '0));
endmodule

// File: rtl/startup_reset_seq.sv
module startup_reset_seq
    import startup_reset_seq_pkg::*;
#(
    parameter int PUP_TICKS   = 72,
    parameter int XTAL_CYCLES = 1024,
    parameter int SYNC_STAGES = 2,
    parameter int PHASES      = 4
) (
    input  logic                       clk,
    input  logic                       por,
    input  logic                       rst_pin_n,
    input  logic                       slow_tick,
    input  logic                       pup_en,
    input  logic [1:0]                 osc_mode,
    output logic                       hold_rst,
    output logic                       restart_pulse,
    output logic [$clog2(PHASES)-1:0]  phase
);
    seq_state_e state, state_nx;
    logic       pin_n_sync;
    logic       pup_done, xtal_done;
    logic       hold_prev;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .por(por), .pin_n(rst_pin_n), .pin_n_sync(pin_n_sync)
    );

    span_counter #(.LIMIT(PUP_TICKS)) u_pup_cnt (
        .clk(clk), .por(por), .run(state == ST_PUP_WAIT),
        .step(slow_tick), .done(pup_done)
    );

    span_counter #(.LIMIT(XTAL_CYCLES)) u_xtal_cnt (
        .clk(clk), .por(por), .run(state == ST_XTAL_WAIT),
        .step(1'b1), .done(xtal_done)
    );

    phase_gen #(.PHASES(PHASES)) u_phase (
        .clk(clk), .por(por), .hold(hold_rst), .phase(phase)
    );

    // State register
    always_ff @(posedge clk or posedge por) begin
        if (por) state <= ST_BOOT;
        else     state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT: begin
                if (pup_en)                      state_nx = ST_PUP_WAIT;
                else if (needs_settle(osc_mode)) state_nx = ST_XTAL_WAIT;
                else                             state_nx = ST_RUN;
            end
            ST_PUP_WAIT: begin
                if (pup_done)
                    state_nx = needs_settle(osc_mode) ? ST_XTAL_WAIT : ST_RUN;
            end
            ST_XTAL_WAIT: begin
                if (xtal_done) state_nx = ST_RUN;
            end
            ST_RUN: state_nx = ST_RUN;
        endcase
    end

    // Output logic
    always_ff @(posedge clk or posedge por) begin
        if (por) hold_prev <= 1'b1;
        else     hold_prev <= hold_rst;
    end

    always_comb begin
        hold_rst      = (state != ST_RUN) || !pin_n_sync;
        restart_pulse = hold_prev && !hold_rst;
    end

    // R1: every state before ST_RUN keeps the core in reset
    a_r1_busy_holds: assert property (@(posedge clk) disable iff (por)
        (state != ST_RUN) |-> hold_rst);

    // R2: the power-up wait only advances on a slow tick
    a_r2_wait_needs_tick: assert property (@(posedge clk) disable iff (por)
        (state == ST_PUP_WAIT) && !slow_tick |=> (state == ST_PUP_WAIT));

    // R6: a pin reset never sends the sequencer back to a wait
    a_r6_run_sticky: assert property (@(posedge clk) disable iff (por)
        (state == ST_RUN) |=> (state == ST_RUN));

    // R8: the restart pulse never lasts two cycles
    a_r8_restart_once: assert property (@(posedge clk) disable iff (por)
        restart_pulse |=> !restart_pulse);

    // R9: the restart cycle is instruction phase 0
    a_r9_restart_phase0: assert property (@(posedge clk) disable iff (por)
        restart_pulse |-> (phase == '0));
endmodule

// File: tb/startup_reset_seq_tb.sv
module startup_reset_seq_tb;
    localparam int PUP = 5;
    localparam int XTL = 16;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       rst_pin_n = 1'b1;
    logic       slow_tick = 1'b0;
    logic       pup_en = 1'b1;
    logic [1:0] osc_mode = 2'b01;
    logic       hold_rst, restart_pulse;
    logic [1:0] phase;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    startup_reset_seq #(.PUP_TICKS(PUP), .XTAL_CYCLES(XTL)) u_dut (
        .clk(clk), .por(por), .rst_pin_n(rst_pin_n), .slow_tick(slow_tick),
        .pup_en(pup_en), .osc_mode(osc_mode), .hold_rst(hold_rst),
        .restart_pulse(restart_pulse), .phase(phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: records the cycle in which a release must appear
    task automatic expect_release(input int c);
        exp_q.push_back(c);
    endtask

    // monitor: pops one expectation per observed release
    always @(negedge clk) begin
        if (!por && restart_pulse) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected restart", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk("R8 restart cycle", cyc, e);
                chk("R9 phase at restart", int'(phase), 0);
            end
        end
    end

    task automatic power_on(input logic pe, input logic [1:0] mode, output int r);
        @(negedge clk);
        por = 1'b1; pup_en = pe; osc_mode = mode; slow_tick = 1'b0;
        step(3);
        chk("R1 hold in por", int'(hold_rst), 1);
        chk("R1 no restart in por", int'(restart_pulse), 0);
        chk("R1 phase in por", int'(phase), 0);
        por = 1'b0;
        r = cyc;
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            step(2); slow_tick = 1'b1; step(1); slow_tick = 1'b0;
        end
    endtask

    task automatic last_tick(input int extra, output int rel);
        step(2);
        slow_tick = 1'b1;
        rel = cyc + 1 + extra;
        expect_release(rel);
        step(1);
        slow_tick = 1'b0;
    endtask

    initial begin
        int r, rel, p;
        // A: power-up wait and crystal settling, ticks during settling
        rst_pin_n = 1'b1;
        power_on(1'b1, 2'b01, r);
        step(1);
        give_ticks(PUP - 1);
        step(10);
        chk("R2 still waiting for last tick", int'(hold_rst), 1);
        last_tick(XTL, rel);
        slow_tick = 1'b1; step(3); slow_tick = 1'b0;   // R10 stray ticks
        while (cyc < rel - 1) step(1);
        chk("R3 hold before settle end", int'(hold_rst), 1);
        step(1);
        chk("R3 R10 released on time", int'(hold_rst), 0);
        step(1); chk("R9 phase 1", int'(phase), 1);
        step(1); chk("R9 phase 2", int'(phase), 2);
        step(1); chk("R9 phase 3", int'(phase), 3);
        step(1); chk("R9 phase wraps", int'(phase), 0);

        // B: no power-up wait, non-crystal mode
        power_on(1'b0, 2'b11, r);
        expect_release(r + 2);
        step(1); chk("R5 R6 sync latency", int'(hold_rst), 1);
        step(1); chk("R4 R5 immediate release", int'(hold_rst), 0);
        step(1); chk("R8 pulse one cycle", int'(restart_pulse), 0);

        // C: power-up wait then non-crystal
        power_on(1'b1, 2'b11, r);
        step(1);
        give_ticks(PUP - 1);
        last_tick(0, rel);
        chk("R4 release after last tick", int'(hold_rst), 0);

        // D: no power-up wait, crystal mode
        power_on(1'b0, 2'b10, r);
        rel = r + 1 + XTL;
        expect_release(rel);
        while (cyc < rel - 1) step(1);
        chk("R3 R5 hold before settle end", int'(hold_rst), 1);
        step(1);
        chk("R3 R5 release after settle", int'(hold_rst), 0);

        // E: pin held low past both waits
        rst_pin_n = 1'b0;
        power_on(1'b1, 2'b00, r);
        step(1);
        give_ticks(PUP);
        step(XTL + 20);
        chk("R7 pin keeps hold", int'(hold_rst), 1);
        rst_pin_n = 1'b1;
        p = cyc;
        expect_release(p + 2);
        step(1); chk("R7 hold one cycle after pin", int'(hold_rst), 1);
        step(1); chk("R7 fast release", int'(hold_rst), 0);

        // F: pin reset from run, with ticks during it
        step(5);
        rst_pin_n = 1'b0;
        step(1); chk("R6 hold not yet", int'(hold_rst), 0);
        step(1); chk("R6 hold after sync", int'(hold_rst), 1);
        give_ticks(PUP + 1);
        chk("R6 pin reset holds", int'(hold_rst), 1);
        rst_pin_n = 1'b1;
        p = cyc;
        expect_release(p + 2);
        step(2);
        chk("R6 no wait re-run", int'(hold_rst), 0);
        step(20);
        chk("R6 stays running", int'(hold_rst), 0);
        chk("R8 all releases seen", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule